// File: doc/BRIEF.md
# Maskable Nested Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a processor core. Each line sets a pending flag. A flag takes part in arbitration only if three conditions hold: the device for that line is enabled, the processor's global enable is open, and the current processing mask leaves the line open. When more than one line is eligible, a fixed order picks the winner, with line 0 first. The winner is taken only when the core strobes the end of an instruction.

On a take, the block does four things:
- It clears the winner's pending flag.
- It presents the service routine's vector address.
- It pushes the interrupted context (mask, type, in-service flag) onto a small stack.
- It loads the winner's processing mask from a writable table.

The response order is fixed, but the processing order comes from the mask table that software writes. The two orders may therefore differ, and a routine can be pre-empted by any line its mask leaves open. A return strobe restores the saved context.

Top module: `irq_nest_arbiter`

## Requirements
- R1: `irq_req` is 1 exactly when `gie` is 1 and some line i has its pending flag set, `dev_en[i]`=1 and `cur_mask[i]`=0; it is combinational on those inputs and state.
- R2: A take happens only on a clock edge where `instr_done`=1, `irq_req`=1 and `rti`=0. `irq_ack` is 1 for the single cycle after that edge and is 0 otherwise.
- R3: Among eligible lines the lowest index wins, whatever the mask table holds.
- R4: On a take, `cur_type` becomes the winner's index and `vec_addr` becomes VEC_BASE + 4*index. Both hold until the next take or return.
- R5: `irq_in[i]`=1 at an edge sets pending flag i. A take clears the winner's flag, unless its `irq_in` bit is also 1 at that edge. Other flags are untouched.
- R6: On a take, `cur_mask` loads the table entry of the winner, read as it was before any write at that same edge. A mask bit of 1 blocks its line and a 0 leaves it open. At reset, entry k has bits k..NSRC-1 set, and `cur_mask` is 0.
- R7: A take pushes (`cur_mask`, `cur_type`, `in_service`) and increments `nest_depth`. An `rti` with `nest_depth`>0 pops the most recent entry into those outputs and decrements `nest_depth`. `rti` wins over a take at the same edge.
- R8: `rti` at `nest_depth`=0 changes no output.
- R9: A take at `nest_depth`=DEPTH still completes per R4–R6, but pushes nothing. It leaves the depth unchanged and sets the sticky `overflow` flag, which only reset clears.
- R10: With `gie`=0 or `dev_en[i]`=0, line i is not taken, but its pending flag is kept.
- R11: After reset, `pending`, `cur_mask`, `nest_depth`, `overflow`, `in_service`, `irq_ack`, `cur_type` and `vec_addr` are all 0.
- R12: `msk_we`=1 writes `msk_wdata` into table entry `msk_sel` at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NSRC | Request lines; a 1 at an edge sets the pending flag |
| dev_en | input | NSRC | Per-device enable |
| gie | input | 1 | Global interrupt enable from the core |
| instr_done | input | 1 | End-of-instruction strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| msk_we | input | 1 | Mask table write enable |
| msk_sel | input | log2(NSRC) | Mask table entry to write |
| msk_wdata | input | NSRC | Mask word to write |
| irq_req | output | 1 | Interrupt request to the core |
| irq_ack | output | 1 | One-cycle take indication |
| vec_addr | output | AW | Vector address of the taken line |
| cur_type | output | log2(NSRC) | Type number of the routine in service |
| in_service | output | 1 | A routine is active |
| cur_mask | output | NSRC | Active processing mask |
| nest_depth | output | log2(DEPTH+1) | Saved contexts on the stack |
| overflow | output | 1 | Sticky nesting overflow |
| pending | output | NSRC | Pending request flags |

## Verification
Directed sequences cover several cases:
- Simultaneous requests on several lines, which shows that the lowest index wins.
- A lower-index request arriving during a routine, which shows that the mask admits it.
- A higher-index request during the same routine, which shows that the mask blocks it.
- Returns that unwind the nesting back to base level.

Further directed runs cover a closed global enable, a disabled device, returns at depth zero, and repeated nesting past the stack size with an all-open mask table. Random traffic then mixes sparse requests, end-of-instruction and return strobes, enable toggles and table rewrites. It is compared every cycle against a bench model, which separates a wrong winner, a wrong vector, a stale mask and a wrong pop.

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter #(
  parameter int NSRC = 8,
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h0100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0]               irq_in,
  input  logic [NSRC-1:0]               dev_en,
  input  logic                          gie,
  input  logic                          instr_done,
  input  logic                          rti,
  input  logic                          msk_we,
  input  logic [$clog2(NSRC)-1:0]       msk_sel,
  input  logic [NSRC-1:0]               msk_wdata,
  output logic                          irq_req,
  output logic                          irq_ack,
  output logic [AW-1:0]                 vec_addr,
  output logic [$clog2(NSRC)-1:0]       cur_type,
  output logic                          in_service,
  output logic [NSRC-1:0]               cur_mask,
  output logic [$clog2(DEPTH+1)-1:0]    nest_depth,
  output logic                          overflow,
  output logic [NSRC-1:0]               pending
);
  localparam int TW = $clog2(NSRC);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DEPTH);

  logic [NSRC-1:0] pend_q, mask_q, elig, pend_clr;
  logic [NSRC-1:0] mtab [NSRC];
  logic [NSRC-1:0] stk_mask [DEPTH];
  logic [TW-1:0]   stk_type [DEPTH];
  logic            stk_act  [DEPTH];
  logic [TW-1:0]   win, type_q;
  logic [DW-1:0]   depth_q, dm1;
  logic            act_q, ovf_q, ack_q, take, pop, full;
  logic [AW-1:0]   vec_q;

  assign elig     = pend_q & dev_en & ~mask_q & {NSRC{gie}};
  assign take     = instr_done & (|elig) & ~rti;
  assign pop      = rti & (depth_q != '0);
  assign full     = depth_q == DW'(DEPTH);
  assign dm1      = depth_q - 1'b1;
  assign pend_clr = take ? (NSRC'(1) << win) : '0;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = TW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | irq_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NSRC; k++) mtab[k] <= {NSRC{1'b1}} << k;
    end else if (msk_we) begin
      mtab[msk_sel] <= msk_wdata;
    end

  always_ff @(posedge clk)
    if (take && !full) begin
      stk_mask[depth_q[SW-1:0]] <= mask_q;
      stk_type[depth_q[SW-1:0]] <= type_q;
      stk_act[depth_q[SW-1:0]]  <= act_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q  <= '0;
      type_q  <= '0;
      act_q   <= 1'b0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      ack_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      ack_q <= take;
      if (pop) begin
        mask_q  <= stk_mask[dm1[SW-1:0]];
        type_q  <= stk_type[dm1[SW-1:0]];
        act_q   <= stk_act[dm1[SW-1:0]];
        depth_q <= dm1;
      end else if (take) begin
        if (full) ovf_q <= 1'b1;
        else      depth_q <= depth_q + 1'b1;
        mask_q <= mtab[win];
        type_q <= win;
        act_q  <= 1'b1;
        vec_q  <= VEC_BASE + (AW'(win) << 2);
      end
    end

  assign irq_req    = |elig;
  assign irq_ack    = ack_q;
  assign vec_addr   = vec_q;
  assign cur_type   = type_q;
  assign in_service = act_q;
  assign cur_mask   = mask_q;
  assign nest_depth = depth_q;
  assign overflow   = ovf_q;
  assign pending    = pend_q;
endmodule

// File: rtl/irq_nest_arbiter_chk.sv
module irq_nest_arbiter_chk #(
  parameter int NSRC = 8,
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h0100
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NSRC-1:0]            irq_in,
  input logic                       gie,
  input logic                       instr_done,
  input logic                       rti,
  input logic                       irq_req,
  input logic                       irq_ack,
  input logic [AW-1:0]              vec_addr,
  input logic [$clog2(NSRC)-1:0]    cur_type,
  input logic [$clog2(DEPTH+1)-1:0] nest_depth,
  input logic                       overflow,
  input logic [NSRC-1:0]            pending
);
  logic [NSRC-1:0] irq_in_q;
  logic            done_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_in_q <= '0;
      done_q   <= 1'b0;
    end else begin
      irq_in_q <= irq_in;
      done_q   <= instr_done;
    end

  AST_NO_REQ_GIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req); // R1
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> done_q); // R2
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> vec_addr == VEC_BASE + (AW'(cur_type) << 2)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (!pending[cur_type] || irq_in_q[cur_type])); // R5
  AST_RTI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && nest_depth != '0) |=> nest_depth == $past(nest_depth) - 1'b1); // R7
  AST_RTI_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && nest_depth == '0) |=> nest_depth == '0); // R8
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= ($clog2(DEPTH+1))'(DEPTH)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
endmodule

bind irq_nest_arbiter irq_nest_arbiter_chk #(
  .NSRC(NSRC), .DEPTH(DEPTH), .AW(AW), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .gie(gie), .instr_done(instr_done),
  .rti(rti), .irq_req(irq_req), .irq_ack(irq_ack), .vec_addr(vec_addr),
  .cur_type(cur_type), .nest_depth(nest_depth), .overflow(overflow), .pending(pending)
);

// File: tb/irq_nest_arbiter_tb_top.sv
module irq_nest_arbiter_tb_top;
  localparam int N = 8;
  localparam int D = 8;
  localparam int AW = 16;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, dev_en = '1, msk_wdata = '0;
  logic gie = 1'b1, instr_done = 1'b0, rti = 1'b0, msk_we = 1'b0;
  logic [2:0] msk_sel = '0;
  logic irq_req, irq_ack, in_service, overflow;
  logic [AW-1:0] vec_addr;
  logic [2:0] cur_type;
  logic [N-1:0] cur_mask, pending;
  logic [3:0] nest_depth;

  irq_nest_arbiter #(.NSRC(N), .DEPTH(D), .AW(AW), .VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dev_en(dev_en), .gie(gie),
    .instr_done(instr_done), .rti(rti), .msk_we(msk_we), .msk_sel(msk_sel),
    .msk_wdata(msk_wdata), .irq_req(irq_req), .irq_ack(irq_ack), .vec_addr(vec_addr),
    .cur_type(cur_type), .in_service(in_service), .cur_mask(cur_mask),
    .nest_depth(nest_depth), .overflow(overflow), .pending(pending));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_pend, m_mask, m_tab [N], s_mask [D];
  int m_type, m_depth, s_type [D];
  bit m_act, m_ovf, m_ack, s_act [D];
  logic [15:0] m_vec;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_set(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_mask = '0; m_type = 0; m_depth = 0;
    m_act = 0; m_ovf = 0; m_ack = 0; m_vec = '0;
    for (int k = 0; k < N; k++) m_tab[k] = 8'hFF << k;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; instr_done = 0; rti = 0; msk_we = 0; gie = 1; dev_en = '1;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    chk("R11 pending", pending, 0);
    chk("R11 cur_mask", cur_mask, 0);
    chk("R11 nest_depth", nest_depth, 0);
    chk("R11 overflow", overflow, 0);
    chk("R11 in_service", in_service, 0);
    chk("R11 irq_ack", irq_ack, 0);
    chk("R11 irq_req", irq_req, 0);
    chk("R11 vec_addr", vec_addr, 0);
    rst_n = 1'b1;
  endtask

  task automatic cyc();
    logic [N-1:0] el, tabw;
    int w;
    bit take, pop;
    #1;
    el = m_pend & dev_en & ~m_mask & {N{gie}};
    chk("R1 irq_req", irq_req, |el);
    w = first_set(el);
    take = instr_done && (el != 0) && !rti;
    pop = rti && (m_depth > 0);
    tabw = (w >= 0) ? m_tab[w] : '0;
    if (take) m_pend = m_pend & ~(8'(1) << w);
    m_pend = m_pend | irq_in;
    m_ack = take;
    if (pop) begin
      m_depth--;
      m_mask = s_mask[m_depth]; m_type = s_type[m_depth]; m_act = s_act[m_depth];
    end else if (take) begin
      if (m_depth == D) m_ovf = 1;
      else begin
        s_mask[m_depth] = m_mask; s_type[m_depth] = m_type; s_act[m_depth] = m_act;
        m_depth++;
      end
      m_mask = tabw; m_type = w; m_act = 1; m_vec = BASE + 16'(w * 4);
    end
    if (msk_we) m_tab[msk_sel] = msk_wdata;
    @(posedge clk);
    #1;
    chk("R2 irq_ack", irq_ack, m_ack);
    chk("R4 vec_addr", vec_addr, m_vec);
    chk("R3 R4 cur_type", cur_type, m_type);
    chk("R5 R10 pending", pending, m_pend);
    chk("R6 R12 cur_mask", cur_mask, m_mask);
    chk("R7 R8 nest_depth", nest_depth, m_depth);
    chk("R7 in_service", in_service, m_act);
    chk("R9 overflow", overflow, m_ovf);
  endtask

  task automatic idle();
    irq_in = '0; instr_done = 0; rti = 0; msk_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5EED1);
    do_reset();
    // R3: several lines together, lowest index wins
    idle(); irq_in = 8'b1010_1000; cyc();
    idle(); instr_done = 1; cyc();
    chk("R3 winner three", cur_type, 3);
    chk("R4 vector three", vec_addr, BASE + 16'h0C);
    // R6: line 1 open under mask of 3, pre-empts
    idle(); irq_in = 8'b0000_0010; cyc();
    idle(); instr_done = 1; cyc();
    chk("R6 preempt depth", nest_depth, 2);
    // R6: 5 and 7 blocked, so no request
    idle(); cyc();
    chk("R6 blocked request", irq_req, 0);
    idle(); rti = 1; cyc();
    chk("R7 restore type", cur_type, 3);
    idle(); rti = 1; cyc();
    chk("R7 base level", in_service, 0);
    // R10: gie low keeps pending
    idle(); gie = 0; instr_done = 1; cyc(); cyc();
    chk("R10 kept pending", pending, 8'b1010_0000);
    gie = 1; dev_en = 8'b0101_1111; cyc();
    chk("R10 device off", irq_ack, 0);
    dev_en = '1;
    // R8: return at base level
    idle(); rti = 1; cyc();
    chk("R8 rti at base", nest_depth, 0);
    // R12: open every table entry, then nest past the stack
    for (int k = 0; k < N; k++) begin idle(); msk_we = 1; msk_sel = 3'(k); msk_wdata = '0; cyc(); end
    idle(); instr_done = 1; cyc(); cyc();
    for (int k = 0; k < D + 1; k++) begin
      idle(); irq_in = 8'b0001_0000; cyc();
      idle(); instr_done = 1; cyc();
    end
    chk("R9 overflow set", overflow, 1);
    chk("R9 depth saturated", nest_depth, D);
    for (int k = 0; k < D + 2; k++) begin idle(); rti = 1; cyc(); end
    chk("R9 sticky after pops", overflow, 1);
    chk("R8 depth zero", nest_depth, 0);
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < N; b++) irq_in[b] = ($urandom % 10) == 0;
      instr_done = ($urandom % 2) == 0;
      rti = ($urandom % 7) == 0;
      gie = ($urandom % 10) != 0;
      dev_en = (($urandom % 8) == 0) ? 8'($urandom) : 8'hFF;
      msk_we = ($urandom % 25) == 0;
      msk_sel = 3'($urandom);
      msk_wdata = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule